// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes over a full-duplex, clock-synchronous serial link. Each frame shifts exactly eight bits out on the transmit data line and, at the same time, eight bits in from the receive data line. The transfer clock is either generated inside the block or taken from an external pin. When it is generated inside, a prescaler selects one of four fixed divisions of the system clock, and an 8-bit reload counter then stretches each half-period of the transfer clock. The sampling edge, the bit order, the prescaler tap and the handshake direction are all run-time inputs.

Data enters through a valid/ready transmit port. A byte is accepted when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` stays low while the one-byte transmit buffer holds a byte that has not started shifting. Received bytes leave through a valid/ready port. `rx_valid` and `rx_data` hold until `rx_ready` is seen high at an edge. There is no back-pressure on the wire itself: a byte that completes while the receive buffer is still full is dropped, and an overrun is flagged. To receive without sending, software loads a dummy byte with transmit and receive both enabled. The bits shifted in during that frame form the received byte.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_valid`=0, `rx_overrun`=0, `rx_irq`=0, `txd`=1, `sclk_out`=1 and `rts_n_out`=1.
- R2: With the internal clock, every half-period of `sclk_out` inside a frame lasts (cfg_reload+1)×D system cycles. D is set by `cfg_psel`: 0→2, 1→16, 2→64, 3→512. Every reload value from 0 to 255 is accepted.
- R3: Between frames `sclk_out` rests at the inverse of `cfg_pol`. In each bit, the first edge leaves the rest level and changes `txd`. The second edge returns to the rest level and samples `rxd`. So with `cfg_pol`=0, data is sampled on rising edges, and with `cfg_pol`=1 on falling edges. A frame has exactly 8 bits, and `txd` is 1 outside frames.
- R4: `cfg_msb_first`=0 sends and receives bit 0 first. `cfg_msb_first`=1 sends and receives bit 7 first.
- R5: A frame starts only while the transmit buffer holds a byte and `cfg_tx_en`=1. The buffer is freed (`tx_ready`=1 again) when the frame starts. A byte accepted on the transmit port makes `tx_ready` low on the next cycle.
- R6: When a frame completes with `cfg_rx_en`=1 and the receive buffer empty or being read in the same cycle, the shifted-in byte appears on `rx_data` with `rx_valid`=1. Both hold until `rx_ready` is seen. With `cfg_rx_en`=0 nothing is stored.
- R7: When a frame completes with `cfg_rx_en`=1 while `rx_valid`=1 and `rx_ready`=0, the new byte is discarded, `rx_data` keeps the old byte and `rx_overrun` goes to 1. The flag clears when the held byte is read.
- R8: `rx_irq` is a one-cycle pulse. With `cfg_irq_err_only`=0 it fires for each stored byte. With `cfg_irq_err_only`=1 it fires only on an overrun.
- R9: With `cfg_hs_off`=0 and `cfg_hs_rts`=0 (CTS mode), no frame starts while `cts_n_in` is 1, and `rts_n_out` stays 1.
- R10: With `cfg_hs_off`=0 and `cfg_hs_rts`=1 (RTS mode), `rts_n_out` is 0 exactly when `cfg_rx_en`=1 and the receive buffer is empty. With `cfg_hs_off`=1, `rts_n_out` is 1 and `cts_n_in` is ignored.
- R11: With `cfg_ext_clk`=1, `sclk_oe`=0, and bits move on the edges of `sclk_in` under the same polarity and order rules.
- R12: `txd_oe` is the inverse of `cfg_txd_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_psel | input | 2 | Prescaler tap (÷2, ÷16, ÷64, ÷512) |
| cfg_reload | input | 8 | Half-period reload value |
| cfg_ext_clk | input | 1 | 1 = transfer clock from `sclk_in` |
| cfg_pol | input | 1 | 0 = sample on rising edge, 1 = on falling edge |
| cfg_msb_first | input | 1 | Bit order |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_hs_off | input | 1 | 1 = handshake disabled |
| cfg_hs_rts | input | 1 | 0 = CTS input mode, 1 = RTS output mode |
| cfg_irq_err_only | input | 1 | Interrupt on overrun only |
| cfg_txd_off | input | 1 | Releases the transmit pin |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_overrun | output | 1 | Byte lost while buffer full |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Drive enable for `txd` |
| rxd | input | 1 | Serial data in |
| cts_n_in | input | 1 | Clear-to-send, active low |
| rts_n_out | output | 1 | Request-to-send, active low |

## Verification
A peer model on the wire checks byte exchanges in both directions under each polarity and bit order. The complementary and asymmetric patterns 0xA5, 0x3C, 0x01 and 0x80 tell apart a reversed bit order, a one-bit slip and a wrong sampling edge. Every edge interval within a frame is timed against the expected half-period over all four prescaler taps and at reload 0 and 255, which exposes an off-by-one in either counter. Frames held off by the transmit enable and the clear-to-send input show the start conditions. Two back-to-back frames into an unread buffer, under both interrupt modes, separate a stored byte from an overrun and show which byte survives.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int PRE_W = 9;

  typedef enum logic [1:0] {
    PS_DIV2   = 2'd0,
    PS_DIV16  = 2'd1,
    PS_DIV64  = 2'd2,
    PS_DIV512 = 2'd3
  } ssx_psel_e;

  // terminal count of the prescaler for a given tap (division minus one)
  function automatic logic [PRE_W-1:0] prescale_last(input logic [1:0] sel);
    logic [PRE_W:0] one_hot;
    case (ssx_psel_e'(sel))
      PS_DIV2:   one_hot = (PRE_W+1)'(1) << 1;
      PS_DIV16:  one_hot = (PRE_W+1)'(1) << 4;
      PS_DIV64:  one_hot = (PRE_W+1)'(1) << 6;
      default:   one_hot = (PRE_W+1)'(1) << 9;
    endcase
    return PRE_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= rst_val;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s > 0) ? s-1 : 0];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssx_baud_gen.sv
module ssx_baud_gen
  import ssx_pkg::*;
#(
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [1:0]          psel,
  input  logic [RELOAD_W-1:0] reload,
  output logic                half_tick
);
  logic [PRE_W-1:0]    pre_cnt;
  logic [PRE_W-1:0]    pre_last;
  logic [RELOAD_W-1:0] baud_cnt;
  logic                pre_wrap;

  assign pre_last  = prescale_last(psel);
  assign pre_wrap  = run && (pre_cnt == pre_last);
  assign half_tick = pre_wrap && (baud_cnt == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      baud_cnt <= '0;
    end else if (!run) begin
      pre_cnt  <= '0;
      baud_cnt <= '0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) baud_cnt <= (baud_cnt == reload) ? '0 : baud_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssx_frame_eng.sv
module ssx_frame_eng #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ext_clk,
  input  logic              pol,
  input  logic              msb_first,
  input  logic              half_tick,
  input  logic              ext_rise,
  input  logic              ext_fall,
  input  logic              rxd_bit,
  output logic              active,
  output logic              sclk_q,
  output logic              txd_q,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  pos;
  logic              drove;
  logic              rest_lvl;
  logic              drive_ev;
  logic              samp_ev;

  assign rest_lvl = ~pol;
  assign pos      = msb_first ? (LAST_IDX - idx) : idx;

  // the edge leaving the rest level launches data, the edge returning samples it
  assign drive_ev = active && (ext_clk ? (pol ? ext_rise : ext_fall)
                                       : (half_tick && (sclk_q == rest_lvl)));
  assign samp_ev  = active && drove && (ext_clk ? (pol ? ext_fall : ext_rise)
                                                : (half_tick && (sclk_q != rest_lvl)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      drove  <= 1'b0;
      sclk_q <= 1'b1;
      txd_q  <= 1'b1;
      tx_sh  <= '0;
      rx_sh  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        sclk_q <= rest_lvl;
        txd_q  <= 1'b1;
        drove  <= 1'b0;
        idx    <= '0;
        if (start) begin
          active <= 1'b1;
          tx_sh  <= load_data;
        end
      end else begin
        if (half_tick && !ext_clk) sclk_q <= ~sclk_q;
        if (drive_ev) begin
          txd_q <= tx_sh[pos];
          drove <= 1'b1;
        end
        if (samp_ev) begin
          rx_sh[pos] <= rxd_bit;
          drove      <= 1'b0;
          if (idx == LAST_IDX) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign rx_word = rx_sh;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int DATA_W      = 8,
  parameter int RELOAD_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_psel,
  input  logic [RELOAD_W-1:0] cfg_reload,
  input  logic                cfg_ext_clk,
  input  logic                cfg_pol,
  input  logic                cfg_msb_first,
  input  logic                cfg_tx_en,
  input  logic                cfg_rx_en,
  input  logic                cfg_hs_off,
  input  logic                cfg_hs_rts,
  input  logic                cfg_irq_err_only,
  input  logic                cfg_txd_off,
  input  logic [DATA_W-1:0]   tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                rx_overrun,
  output logic                rx_irq,
  input  logic                sclk_in,
  output logic                sclk_out,
  output logic                sclk_oe,
  output logic                txd,
  output logic                txd_oe,
  input  logic                rxd,
  input  logic                cts_n_in,
  output logic                rts_n_out
);
  logic [DATA_W-1:0] tx_buf;
  logic              tx_full;
  logic [DATA_W-1:0] rx_buf;
  logic              rx_full;
  logic              ovr_q;
  logic              irq_q;

  logic              eng_active;
  logic              eng_done;
  logic [DATA_W-1:0] eng_word;
  logic              half_tick;
  logic              start;
  logic              hs_ok;
  logic              cts_sync;
  logic [1:0]        pin_sync;
  logic              sclk_s_d;
  logic              ext_rise;
  logic              ext_fall;
  logic              rxd_bit;
  logic              pop;

  // pin synchronisers: bit 1 = external clock, bit 0 = receive data
  ssx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (2'b11),
    .d       ({sclk_in, rxd}),
    .q       (pin_sync)
  );

  ssx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_cts_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (1'b1),
    .d       (cts_n_in),
    .q       (cts_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_s_d <= 1'b1;
    else        sclk_s_d <= pin_sync[1];
  end

  assign ext_rise = pin_sync[1] & ~sclk_s_d;
  assign ext_fall = ~pin_sync[1] & sclk_s_d;
  // the generated clock leaves the pin directly, so the pin is sampled as is
  assign rxd_bit  = cfg_ext_clk ? pin_sync[0] : rxd;

  ssx_baud_gen #(.RELOAD_W(RELOAD_W)) i_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_active && !cfg_ext_clk),
    .psel      (cfg_psel),
    .reload    (cfg_reload),
    .half_tick (half_tick)
  );

  assign hs_ok = cfg_hs_off || cfg_hs_rts || !cts_sync;
  assign start = tx_full && cfg_tx_en && hs_ok && !eng_active;

  ssx_frame_eng #(.DATA_W(DATA_W)) i_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_data (tx_buf),
    .ext_clk   (cfg_ext_clk),
    .pol       (cfg_pol),
    .msb_first (cfg_msb_first),
    .half_tick (half_tick),
    .ext_rise  (ext_rise),
    .ext_fall  (ext_fall),
    .rxd_bit   (rxd_bit),
    .active    (eng_active),
    .sclk_q    (sclk_out),
    .txd_q     (txd),
    .done      (eng_done),
    .rx_word   (eng_word)
  );

  // transmit buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else if (tx_valid && !tx_full) begin
      tx_full <= 1'b1;
      tx_buf  <= tx_data;
    end else if (start) begin
      tx_full <= 1'b0;
    end
  end

  // receive buffer, overrun and interrupt
  assign pop = rx_full && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_buf  <= '0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (pop) begin
        rx_full <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (eng_done && cfg_rx_en) begin
        if (rx_full && !rx_ready) begin
          ovr_q <= 1'b1;
          irq_q <= cfg_irq_err_only;
        end else begin
          rx_full <= 1'b1;
          rx_buf  <= eng_word;
          irq_q   <= !cfg_irq_err_only;
        end
      end
    end
  end

  assign tx_ready   = !tx_full;
  assign rx_valid   = rx_full;
  assign rx_data    = rx_buf;
  assign rx_overrun = ovr_q;
  assign rx_irq     = irq_q;
  assign sclk_oe    = !cfg_ext_clk;
  assign txd_oe     = !cfg_txd_off;
  assign rts_n_out  = cfg_hs_off || !cfg_hs_rts || !(cfg_rx_en && !rx_full);
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_pol,
  input logic              cfg_hs_off,
  input logic              cfg_hs_rts,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_overrun,
  input logic              rx_irq,
  input logic              sclk_out,
  input logic              eng_active,
  input logic              cts_sync
);
  assert_tx_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_overrun_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_valid);

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_rest_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_active && $past(!eng_active) && $stable(cfg_pol)) |-> (sclk_out == !cfg_pol));

  assert_cts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hs_off && !cfg_hs_rts && cts_sync && !eng_active) |=> !eng_active);
endmodule

bind sync_serial_xcvr ssx_checker #(.DATA_W(DATA_W)) i_ssx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_pol    (cfg_pol),
  .cfg_hs_off (cfg_hs_off),
  .cfg_hs_rts (cfg_hs_rts),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_overrun (rx_overrun),
  .rx_irq     (rx_irq),
  .sclk_out   (sclk_out),
  .eng_active (eng_active),
  .cts_sync   (cts_sync)
);

// File: tb/test_sync_serial_xcvr.sv
`timescale 1ns/1ps
module test_sync_serial_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_psel = 2'd0;
  logic [7:0] cfg_reload = 8'd1;
  logic cfg_ext_clk = 1'b0, cfg_pol = 1'b0, cfg_msb_first = 1'b0;
  logic cfg_tx_en = 1'b1, cfg_rx_en = 1'b1, cfg_hs_off = 1'b1, cfg_hs_rts = 1'b0;
  logic cfg_irq_err_only = 1'b0, cfg_txd_off = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic sclk_in = 1'b1, rxd = 1'b1, cts_n_in = 1'b1;
  logic tx_ready, rx_valid, rx_overrun, rx_irq, sclk_out, sclk_oe, txd, txd_oe, rts_n_out;
  logic [7:0] rx_data;

  sync_serial_xcvr i_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_psel(cfg_psel), .cfg_reload(cfg_reload),
    .cfg_ext_clk(cfg_ext_clk), .cfg_pol(cfg_pol), .cfg_msb_first(cfg_msb_first),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_hs_off(cfg_hs_off),
    .cfg_hs_rts(cfg_hs_rts), .cfg_irq_err_only(cfg_irq_err_only), .cfg_txd_off(cfg_txd_off),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rx_irq(rx_irq), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .txd(txd), .txd_oe(txd_oe), .rxd(rxd),
    .cts_n_in(cts_n_in), .rts_n_out(rts_n_out));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int edge_cnt = 0;
  bit model_en = 1'b0;
  bit done_all = 1'b0;

  logic [7:0] slv_q[$];
  logic [7:0] exp_tx_q[$];
  logic [7:0] exp_rx_q[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int half_period(input logic [1:0] ps, input logic [7:0] rl);
    int d;
    case (ps)
      2'd0: d = 2;
      2'd1: d = 16;
      2'd2: d = 64;
      default: d = 512;
    endcase
    return (int'(rl) + 1) * d;
  endfunction

  // peer on the wire for the generated clock: launches rxd, samples txd
  int sbit = 0;
  int last_edge = 0;
  bit bad_period = 1'b0;
  logic [7:0] cur_slv = 8'h00;
  logic [7:0] srx = 8'h00;
  always @(sclk_out) begin
    #1;
    if (model_en && rst_n && !cfg_ext_clk) begin
      automatic int p = cfg_msb_first ? 7 - sbit : sbit;
      edge_cnt++;
      if (!(sbit == 0 && sclk_out != !cfg_pol)) begin
        if (cyc - last_edge != half_period(cfg_psel, cfg_reload)) bad_period = 1'b1;
      end
      last_edge = cyc;
      if (sclk_out != !cfg_pol) begin
        if (sbit == 0) begin
          bad_period = 1'b0;
          cur_slv = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
        end
        rxd = cur_slv[p];
      end else begin
        srx[p] = txd;
        sbit++;
        if (sbit == 8) begin
          automatic logic [7:0] e = (exp_tx_q.size() > 0) ? exp_tx_q.pop_front() : 8'hxx;
          sbit = 0;
          // R3 R4: byte seen on the wire, bit order and sampling edge
          check(srx === e, "R3/R4 wire byte", srx, e);
          // R2: every half-period in this frame
          check(!bad_period, "R2 half period", half_period(cfg_psel, cfg_reload), 0);
        end
      end
    end
  end

  // scoreboard monitor for the receive port
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      automatic logic [7:0] e = (exp_rx_q.size() > 0) ? exp_rx_q.pop_front() : 8'hxx;
      check(rx_data === e, "R6 received byte", rx_data, e);
    end
  end

  task automatic send(input logic [7:0] tb, input logic [7:0] sb, input bit push_rx);
    slv_q.push_back(sb);
    exp_tx_q.push_back(tb);
    if (push_rx) exp_rx_q.push_back(sb);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = tb;
    tx_valid = 1'b1;
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic wait_quiet(input string tag);
    int n = 0;
    @(negedge clk);
    while ((exp_tx_q.size() != 0 || !tx_ready) && n < 40000) begin
      @(negedge clk);
      n++;
    end
    check(n < 40000, tag, n, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] ps, input logic [7:0] rl, input logic pl, input logic mf);
    model_en = 1'b0;
    cfg_psel = ps; cfg_reload = rl; cfg_pol = pl; cfg_msb_first = mf;
    repeat (3) @(posedge clk);
    #1 model_en = 1'b1;
  endtask

  task automatic ext_frame(input logic [7:0] mb, output logic [7:0] got);
    for (int b = 0; b < 8; b++) begin
      automatic int p = cfg_msb_first ? 7 - b : b;
      @(negedge clk);
      sclk_in = cfg_pol;
      rxd = mb[p];
      repeat (8) @(negedge clk);
      got[p] = txd;
      sclk_in = !cfg_pol;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int irq0;
    int e0;
    logic [7:0] got;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_ready === 1'b1 && rx_valid === 1'b0 && rx_overrun === 1'b0 && rx_irq === 1'b0,
          "R1 reset flags", {tx_ready, rx_valid, rx_overrun, rx_irq}, 4'b1000);
    check(txd === 1'b1 && sclk_out === 1'b1 && rts_n_out === 1'b1,
          "R1 reset pins", {txd, sclk_out, rts_n_out}, 3'b111);
    check(sclk_oe === 1'b1 && txd_oe === 1'b1, "R12 output enables", {sclk_oe, txd_oe}, 2'b11);
    model_en = 1'b1;

    // main function: rising-edge sampling, LSB first
    irq0 = irq_cnt;
    send(8'hA5, 8'h3C, 1'b1);
    send(8'h01, 8'h80, 1'b1);
    wait_quiet("R5 frames complete");
    check(irq_cnt - irq0 == 2, "R8 irq per byte", irq_cnt - irq0, 2);

    // falling-edge sampling, MSB first, divide by 16
    set_cfg(2'd1, 8'd0, 1'b1, 1'b1);
    @(negedge clk);
    check(sclk_out === 1'b0, "R3 rest level pol1", sclk_out, 0);
    send(8'h3C, 8'hA5, 1'b1);
    send(8'h80, 8'h01, 1'b1);
    wait_quiet("R4 msb frames complete");

    // remaining taps and reload extremes
    set_cfg(2'd2, 8'd2, 1'b0, 1'b1);
    send(8'h5A, 8'hC3, 1'b1);
    wait_quiet("R2 div64 frame");
    set_cfg(2'd3, 8'd0, 1'b1, 1'b0);
    send(8'hF0, 8'h0F, 1'b1);
    wait_quiet("R2 div512 frame");
    set_cfg(2'd0, 8'd255, 1'b0, 1'b0);
    send(8'h69, 8'h96, 1'b1);
    wait_quiet("R2 reload 255 frame");
    set_cfg(2'd0, 8'd0, 1'b0, 1'b0);
    send(8'hC3, 8'h7E, 1'b1);
    wait_quiet("R2 reload 0 frame");
    set_cfg(2'd0, 8'd1, 1'b0, 1'b0);

    // R5: transmit disabled holds the byte
    cfg_tx_en = 1'b0;
    e0 = edge_cnt;
    send(8'h11, 8'h22, 1'b1);
    repeat (200) @(negedge clk);
    check(tx_ready === 1'b0 && edge_cnt == e0, "R5 held while tx disabled", edge_cnt - e0, 0);
    cfg_tx_en = 1'b1;
    wait_quiet("R5 frame after enable");

    // R9: CTS mode blocks until clear-to-send
    cfg_hs_off = 1'b0; cfg_hs_rts = 1'b0; cts_n_in = 1'b1;
    e0 = edge_cnt;
    send(8'h33, 8'h44, 1'b1);
    repeat (200) @(negedge clk);
    check(tx_ready === 1'b0 && edge_cnt == e0 && rts_n_out === 1'b1,
          "R9 held by cts", edge_cnt - e0, 0);
    cts_n_in = 1'b0;
    wait_quiet("R9 frame after cts");
    cts_n_in = 1'b1;

    // R10: RTS follows receive buffer space
    cfg_hs_rts = 1'b1;
    @(negedge clk);
    check(rts_n_out === 1'b0, "R10 rts low when empty", rts_n_out, 0);
    rx_ready = 1'b0;
    send(8'h55, 8'h66, 1'b1);
    wait_quiet("R10 frame");
    check(rts_n_out === 1'b1 && rx_valid === 1'b1, "R10 rts high when full", rts_n_out, 1);
    rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(rts_n_out === 1'b0, "R10 rts low after read", rts_n_out, 0);
    cfg_hs_off = 1'b1;
    @(negedge clk);
    check(rts_n_out === 1'b1, "R10 rts idle when handshake off", rts_n_out, 1);

    // R7 R8: overrun in error-only interrupt mode
    cfg_irq_err_only = 1'b1;
    rx_ready = 1'b0;
    irq0 = irq_cnt;
    send(8'h12, 8'h77, 1'b1);
    wait_quiet("R7 first frame");
    check(irq_cnt - irq0 == 0, "R8 no irq on good byte in error mode", irq_cnt - irq0, 0);
    send(8'h34, 8'h88, 1'b0);
    wait_quiet("R7 second frame");
    check(rx_overrun === 1'b1, "R7 overrun flag", rx_overrun, 1);
    check(rx_data === 8'h77, "R7 old byte kept", rx_data, 8'h77);
    check(irq_cnt - irq0 == 1, "R8 irq on overrun", irq_cnt - irq0, 1);
    rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(rx_overrun === 1'b0 && rx_valid === 1'b0, "R7 cleared by read", rx_overrun, 0);
    cfg_irq_err_only = 1'b0;

    // R6: receive disabled stores nothing
    cfg_rx_en = 1'b0;
    irq0 = irq_cnt;
    send(8'h9C, 8'hE1, 1'b0);
    wait_quiet("R6 tx-only frame");
    check(rx_valid === 1'b0 && irq_cnt == irq0, "R6 nothing stored when rx off", rx_valid, 0);
    cfg_rx_en = 1'b1;

    // R12: transmit pin release
    cfg_txd_off = 1'b1;
    @(negedge clk);
    check(txd_oe === 1'b0, "R12 txd released", txd_oe, 0);
    cfg_txd_off = 1'b0;

    // R11: external clock, MSB first, rising-edge sampling
    model_en = 1'b0;
    cfg_ext_clk = 1'b1; cfg_pol = 1'b0; cfg_msb_first = 1'b1;
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    check(sclk_oe === 1'b0, "R11 clock pin released", sclk_oe, 0);
    exp_rx_q.push_back(8'hB4);
    @(negedge clk);
    tx_data = 8'h4D; tx_valid = 1'b1;
    @(posedge clk);
    #1 tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    ext_frame(8'hB4, got);
    check(got === 8'h4D, "R11 external clock tx byte", got, 8'h4D);
    repeat (8) @(negedge clk);
    check(exp_rx_q.size() == 0, "R11 external clock rx byte", exp_rx_q.size(), 0);

    done_all = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule